// File: doc/BRIEF.md
# Block-Transfer Address Sequencer

This block turns one multi-word transfer command into a run of single-word memory accesses. A command carries a base address, a register-select mask, the index of the register that holds the base, a load/store flag, a three-bit walk mode and a writeback request. The sequencer visits each selected register once and, for each, offers a register index, a word address and the load/store flag on a valid/ready access port. Each access moves one word of `WORD_BYTES` bytes.

Eight walk modes are accepted. Four name the address walk directly: increment or decrement, with the step taken before or after each access. Four name a stack discipline: full or empty, ascending or descending. A stack mode resolves to a direct walk according to the load/store flag. Whatever the mode, the lowest-numbered register always lands on the lowest address, so every walk emits ascending addresses. When the last access is accepted, a one-cycle done pulse reports the final base value, whether writeback applies, and whether the command was illegal. An illegal command issues no accesses at all.

Top module: `blkxfer_seq`

## Requirements
- R1: Accesses of one command carry the selected register indices in strictly ascending numeric order, one access per set mask bit. Each access after the first has an address `WORD_BYTES` above the one before it.
- R2: Mode 0 (increment, step after): the first address equals the base.
- R3: Mode 1 (increment, step before): the first address equals base + `WORD_BYTES`.
- R4: Mode 2 (decrement, step after): with N set mask bits, the first address equals base − `WORD_BYTES`·N + `WORD_BYTES`.
- R5: Mode 3 (decrement, step before): the first address equals base − `WORD_BYTES`·N.
- R6: Stack modes resolve to direct modes. For loads: 4 (full descending) acts as 0, 5 (empty descending) as 1, 6 (full ascending) as 2, and 7 (empty ascending) as 3. For stores: 4 acts as 3, 5 as 2, 6 as 1, and 7 as 0.
- R7: For a legal command, `done_base` equals base + `WORD_BYTES`·N in modes that resolve to 0 or 1, and base − `WORD_BYTES`·N in modes that resolve to 2 or 3, all modulo 2^`ADDR_W`. `done_wb` equals the writeback request.
- R8: An all-zero mask is illegal. It produces no access, and `done` rises in the cycle after acceptance with `done_err`=1, `done_wb`=0 and `done_base` equal to the base.
- R9: A writeback request while the mask bit at `cmd_base_idx` is set is illegal. It is handled exactly as in R8.
- R10: For a legal command, `done` is high for exactly the cycle after the accepted last access, with `done_err`=0, and `acc_valid` is low in that cycle.
- R11: While `acc_valid` is high and `acc_ready` is low, `acc_valid`, `acc_idx` and `acc_addr` hold their values into the next cycle.
- R12: After reset, `cmd_ready`=1, `acc_valid`=0 and `done`=0. `cmd_ready` is low whenever `acc_valid` is high.
- R13: `acc_load` equals the load flag of the command being sequenced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle; command accepted when both are high |
| cmd_base | input | ADDR_W | Base address |
| cmd_mask | input | NREG | Register-select mask, bit i selects register i |
| cmd_base_idx | input | $clog2(NREG) | Register number holding the base |
| cmd_load | input | 1 | 1 = load, 0 = store |
| cmd_mode | input | 3 | Walk mode, 0..3 direct, 4..7 stack (see R2–R6) |
| cmd_wb | input | 1 | Writeback of the final base requested |
| acc_valid | output | 1 | Access offered |
| acc_ready | input | 1 | Memory side accepts the access |
| acc_idx | output | $clog2(NREG) | Register index of the access |
| acc_addr | output | ADDR_W | Word address of the access |
| acc_load | output | 1 | Load/store flag of the access |
| done | output | 1 | One-cycle end-of-command pulse |
| done_base | output | ADDR_W | Final base value |
| done_wb | output | 1 | Writeback applies |
| done_err | output | 1 | Command was illegal |

## Verification
The bench builds the sequencer with `NREG`=8, `ADDR_W`=32 and `WORD_BYTES`=4. With eight mask bits, all 256 masks can be swept against every mode, both directions and both writeback settings. This reaches the empty mask, single-register masks, the full mask and every case of the base register sitting inside the mask. Bases near zero and near the top of the address space make the decrement starts and the final base wrap. A repeating `acc_ready` pattern causes stalls at varying positions within each walk.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;

   // Resolved address walk; encoding equals direct mode codes 0..3.
   typedef enum logic [1:0] {
      WALK_INC_AFTER  = 2'd0,
      WALK_INC_BEFORE = 2'd1,
      WALK_DEC_AFTER  = 2'd2,
      WALK_DEC_BEFORE = 2'd3
   } walk_e;

endpackage

// File: rtl/blkxfer_mode_map.sv
module blkxfer_mode_map
   import blkxfer_pkg::*;
#(
   parameter bit STACK_EN = 1'b1
) (
   input  logic [2:0] mode,
   input  logic       is_load,
   output walk_e      walk
);

   generate
      if (STACK_EN) begin : g_stack
         // Stack codes: loads take the low bits as is, stores take them inverted.
         assign walk = walk_e'((mode[2] && !is_load) ? ~mode[1:0] : mode[1:0]);
      end else begin : g_direct
         logic unused_mode_bits;
         assign unused_mode_bits = mode[2] ^ is_load;
         assign walk = walk_e'(mode[1:0]);
      end
   endgenerate

endmodule

// File: rtl/blkxfer_addr_plan.sv
module blkxfer_addr_plan
   import blkxfer_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int NREG       = 16,
   parameter int WORD_BYTES = 4
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [NREG-1:0]   mask,
   input  walk_e             walk,
   output logic              none_sel,
   output logic [ADDR_W-1:0] first_addr,
   output logic [ADDR_W-1:0] final_addr
);

   localparam int CNT_W = $clog2(NREG + 1);
   localparam int SH    = $clog2(WORD_BYTES);

   logic [CNT_W-1:0]  cnt;
   logic [ADDR_W-1:0] span;
   logic [ADDR_W-1:0] step;

   always_comb begin
      cnt = '0;
      for (int i = 0; i < NREG; i++) begin
         cnt = cnt + CNT_W'(mask[i]);
      end
   end

   assign none_sel = (cnt == '0);
   assign span     = ADDR_W'(cnt) << SH;
   assign step     = ADDR_W'(WORD_BYTES);

   always_comb begin
      unique case (walk)
         WALK_INC_AFTER: begin
            first_addr = base;
            final_addr = base + span;
         end
         WALK_INC_BEFORE: begin
            first_addr = base + step;
            final_addr = base + span;
         end
         WALK_DEC_AFTER: begin
            first_addr = base - span + step;
            final_addr = base - span;
         end
         default: begin
            first_addr = base - span;
            final_addr = base - span;
         end
      endcase
   end

endmodule

// File: rtl/blkxfer_pick.sv
module blkxfer_pick #(
   parameter int NREG = 16
) (
   input  logic [NREG-1:0]         vec,
   output logic [$clog2(NREG)-1:0] idx,
   output logic                    single
);

   localparam int IDX_W = $clog2(NREG);

   // Lowest set bit wins: scan downward so the last hit is the lowest.
   always_comb begin
      idx = '0;
      for (int i = NREG - 1; i >= 0; i--) begin
         if (vec[i]) idx = IDX_W'(i);
      end
   end

   assign single = ((vec & (vec - NREG'(1))) == '0);

endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq
   import blkxfer_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int NREG       = 16,
   parameter int WORD_BYTES = 4,
   parameter bit STACK_EN   = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cmd_valid,
   output logic                    cmd_ready,
   input  logic [ADDR_W-1:0]       cmd_base,
   input  logic [NREG-1:0]         cmd_mask,
   input  logic [$clog2(NREG)-1:0] cmd_base_idx,
   input  logic                    cmd_load,
   input  logic [2:0]              cmd_mode,
   input  logic                    cmd_wb,
   output logic                    acc_valid,
   input  logic                    acc_ready,
   output logic [$clog2(NREG)-1:0] acc_idx,
   output logic [ADDR_W-1:0]       acc_addr,
   output logic                    acc_load,
   output logic                    done,
   output logic [ADDR_W-1:0]       done_base,
   output logic                    done_wb,
   output logic                    done_err
);

   localparam int IDX_W = $clog2(NREG);

   generate
      if (NREG < 2 || (NREG & (NREG - 1)) != 0) begin : g_bad_nreg
         $error("blkxfer_seq: NREG must be a power of two, at least 2");
      end
      if (WORD_BYTES < 1 || (WORD_BYTES & (WORD_BYTES - 1)) != 0) begin : g_bad_word
         $error("blkxfer_seq: WORD_BYTES must be a power of two");
      end
      if (ADDR_W < 8) begin : g_bad_addr
         $error("blkxfer_seq: ADDR_W must be at least 8");
      end
   endgenerate

   walk_e             walk;
   logic              none_sel;
   logic [ADDR_W-1:0] first_addr;
   logic [ADDR_W-1:0] final_addr;
   logic              illegal;
   logic              accept;
   logic              single;

   logic              run_q;
   logic [NREG-1:0]   rem_q;
   logic [ADDR_W-1:0] addr_q;
   logic              load_q;
   logic [ADDR_W-1:0] pend_base_q;
   logic              pend_wb_q;
   logic              done_q;
   logic [ADDR_W-1:0] done_base_q;
   logic              done_wb_q;
   logic              done_err_q;

   blkxfer_mode_map #(.STACK_EN(STACK_EN)) u_map (
      .mode    (cmd_mode),
      .is_load (cmd_load),
      .walk    (walk)
   );

   blkxfer_addr_plan #(.ADDR_W(ADDR_W), .NREG(NREG), .WORD_BYTES(WORD_BYTES)) u_plan (
      .base       (cmd_base),
      .mask       (cmd_mask),
      .walk       (walk),
      .none_sel   (none_sel),
      .first_addr (first_addr),
      .final_addr (final_addr)
   );

   blkxfer_pick #(.NREG(NREG)) u_pick (
      .vec    (rem_q),
      .idx    (acc_idx),
      .single (single)
   );

   assign cmd_ready = !run_q;
   assign accept    = cmd_valid && cmd_ready;
   assign illegal   = none_sel || (cmd_wb && cmd_mask[cmd_base_idx]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q       <= 1'b0;
         rem_q       <= '0;
         addr_q      <= '0;
         load_q      <= 1'b0;
         pend_base_q <= '0;
         pend_wb_q   <= 1'b0;
         done_q      <= 1'b0;
         done_base_q <= '0;
         done_wb_q   <= 1'b0;
         done_err_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            load_q <= cmd_load;
            if (illegal) begin
               done_q      <= 1'b1;
               done_err_q  <= 1'b1;
               done_wb_q   <= 1'b0;
               done_base_q <= cmd_base;
            end else begin
               run_q       <= 1'b1;
               rem_q       <= cmd_mask;
               addr_q      <= first_addr;
               pend_base_q <= final_addr;
               pend_wb_q   <= cmd_wb;
            end
         end
         if (run_q && acc_ready) begin
            rem_q  <= rem_q & (rem_q - NREG'(1));
            addr_q <= addr_q + ADDR_W'(WORD_BYTES);
            if (single) begin
               run_q       <= 1'b0;
               done_q      <= 1'b1;
               done_err_q  <= 1'b0;
               done_wb_q   <= pend_wb_q;
               done_base_q <= pend_base_q;
            end
         end
      end
   end

   assign acc_valid = run_q;
   assign acc_addr  = addr_q;
   assign acc_load  = load_q;
   assign done      = done_q;
   assign done_base = done_base_q;
   assign done_wb   = done_wb_q;
   assign done_err  = done_err_q;

endmodule

// File: rtl/blkxfer_chk.sv
module blkxfer_chk #(
   parameter int ADDR_W     = 32,
   parameter int NREG       = 16,
   parameter int WORD_BYTES = 4
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    cmd_valid,
   input logic                    cmd_ready,
   input logic [NREG-1:0]         cmd_mask,
   input logic [$clog2(NREG)-1:0] cmd_base_idx,
   input logic                    cmd_wb,
   input logic                    acc_valid,
   input logic                    acc_ready,
   input logic [$clog2(NREG)-1:0] acc_idx,
   input logic [ADDR_W-1:0]       acc_addr,
   input logic                    done,
   input logic                    done_wb,
   input logic                    done_err
);

   p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid && !acc_ready |=> acc_valid && $stable(acc_addr) && $stable(acc_idx));

   p_addr_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid && acc_ready |=> !acc_valid || (acc_addr == $past(acc_addr) + ADDR_W'(WORD_BYTES)));

   p_idx_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid && acc_ready |=> !acc_valid || (acc_idx > $past(acc_idx)));

   p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !acc_valid);

   p_busy_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready |-> !acc_valid);

   p_empty_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_ready && (cmd_mask == '0) |=> done && done_err && !acc_valid);

   p_base_wb_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_ready && cmd_wb && cmd_mask[cmd_base_idx] |=> done && done_err && !done_wb);

endmodule

bind blkxfer_seq blkxfer_chk #(.ADDR_W(ADDR_W), .NREG(NREG), .WORD_BYTES(WORD_BYTES)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cmd_valid    (cmd_valid),
   .cmd_ready    (cmd_ready),
   .cmd_mask     (cmd_mask),
   .cmd_base_idx (cmd_base_idx),
   .cmd_wb       (cmd_wb),
   .acc_valid    (acc_valid),
   .acc_ready    (acc_ready),
   .acc_idx      (acc_idx),
   .acc_addr     (acc_addr),
   .done         (done),
   .done_wb      (done_wb),
   .done_err     (done_err)
);

// File: tb/blkxfer_seq_tb.sv
module blkxfer_seq_tb;

   localparam int AW = 32;
   localparam int NR = 8;
   localparam int IW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic          cmd_ready;
   logic [AW-1:0] cmd_base = '0;
   logic [NR-1:0] cmd_mask = '0;
   logic [IW-1:0] cmd_base_idx = '0;
   logic          cmd_load = 1'b0;
   logic [2:0]    cmd_mode = '0;
   logic          cmd_wb = 1'b0;
   logic          acc_valid;
   logic          acc_ready = 1'b0;
   logic [IW-1:0] acc_idx;
   logic [AW-1:0] acc_addr;
   logic          acc_load;
   logic          done;
   logic [AW-1:0] done_base;
   logic          done_wb;
   logic          done_err;

   int total = 0;
   int bad   = 0;
   int rdy_phase = 0;

   always #2.5 clk = ~clk;

   blkxfer_seq #(.ADDR_W(AW), .NREG(NR), .WORD_BYTES(4), .STACK_EN(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_base(cmd_base),
      .cmd_mask(cmd_mask), .cmd_base_idx(cmd_base_idx), .cmd_load(cmd_load),
      .cmd_mode(cmd_mode), .cmd_wb(cmd_wb),
      .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_idx(acc_idx),
      .acc_addr(acc_addr), .acc_load(acc_load),
      .done(done), .done_base(done_base), .done_wb(done_wb), .done_err(done_err)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic run_cmd(input logic [AW-1:0] b, input logic [NR-1:0] m, input logic ld,
                          input logic [2:0] md, input logic wb, input logic [IW-1:0] bi);
      int          n = 0;
      int          idxs[NR];
      int          code;
      logic [AW-1:0] span, first, fin;
      bit          err;
      string       tag;
      int          k = 0;
      int          cyc = 0;
      int          last_hs = -1;
      bit          seen_done = 0;
      bit          prev_stall = 0;
      bit          rdy;
      for (int i = 0; i < NR; i++) if (m[i]) begin idxs[n] = i; n++; end
      // R6: stack codes 4..7 resolve by direction
      code = (md < 3'd4) ? int'(md) : (ld ? int'(md) - 4 : 3 - (int'(md) - 4));
      span = AW'(n * 4);
      case (code)
         0: begin first = b;            fin = b + span; tag = "R2"; end
         1: begin first = b + 4;        fin = b + span; tag = "R3"; end
         2: begin first = b - span + 4; fin = b - span; tag = "R4"; end
         default: begin first = b - span; fin = b - span; tag = "R5"; end
      endcase
      if (md >= 3'd4) tag = "R6";
      err = (n == 0) || (wb && m[bi]);

      @(negedge clk);
      check(cmd_ready == 1'b1, "R12", "cmd_ready idle", cmd_ready, 1);
      cmd_base = b; cmd_mask = m; cmd_load = ld; cmd_mode = md; cmd_wb = wb; cmd_base_idx = bi;
      cmd_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;
      while (cyc < 40) begin
         if (prev_stall)
            check(acc_valid == 1'b1, "R11", "valid held in stall", acc_valid, 1);
         if (done) begin
            seen_done = 1;
            check(acc_valid == 1'b0, "R10", "valid low at done", acc_valid, 0);
            if (err) begin
               check(done_err == 1'b1, (n == 0) ? "R8" : "R9", "done_err", done_err, 1);
               check(cyc == 0, (n == 0) ? "R8" : "R9", "done latency", cyc, 0);
               check(k == 0, (n == 0) ? "R8" : "R9", "no accesses", k, 0);
               check(done_wb == 1'b0, "R9", "done_wb on error", done_wb, 0);
               check(done_base == b, "R8", "done_base on error", done_base, b);
            end else begin
               check(done_err == 1'b0, "R10", "done_err", done_err, 0);
               check(cyc == last_hs + 1, "R10", "done cycle", cyc, last_hs + 1);
               check(k == n, "R1", "access count", k, n);
               check(done_wb == wb, "R7", "done_wb", done_wb, wb);
               check(done_base == fin, "R7", "done_base", done_base, fin);
            end
            break;
         end
         if (acc_valid) begin
            if (k >= n) begin
               check(1'b0, "R1", "extra access", k, n);
            end else begin
               check(acc_idx == IW'(idxs[k]), "R1", "acc_idx", acc_idx, idxs[k]);
               check(acc_addr == first + AW'(4 * k), tag, "acc_addr", acc_addr, first + AW'(4 * k));
               check(acc_load == ld, "R13", "acc_load", acc_load, ld);
            end
         end
         rdy = (rdy_phase % 3) != 2;
         rdy_phase++;
         acc_ready = rdy;
         prev_stall = acc_valid && !rdy;
         if (acc_valid && rdy) begin
            last_hs = cyc;
            k++;
         end
         @(posedge clk);
         @(negedge clk);
         cyc++;
      end
      acc_ready = 1'b0;
      if (!seen_done) check(1'b0, "R10", "done never seen", 0, 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL R10 watchdog actual=%0d expected=%0d", 200000, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [AW-1:0] bases[3];
      bases[0] = 32'h0000_0010;
      bases[1] = 32'h8000_0000;
      bases[2] = 32'hFFFF_FFF0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(cmd_ready == 1'b1, "R12", "reset cmd_ready", cmd_ready, 1);
      check(acc_valid == 1'b0, "R12", "reset acc_valid", acc_valid, 0);
      check(done == 1'b0, "R12", "reset done", done, 0);
      rst_n = 1'b1;
      for (int md = 0; md < 8; md++) begin
         for (int ld = 0; ld < 2; ld++) begin
            for (int wb = 0; wb < 2; wb++) begin
               for (int m = 0; m < 256; m++) begin
                  run_cmd(bases[(m + md) % 3], NR'(m), ld[0], 3'(md), wb[0], IW'((m + md + ld) % NR));
               end
            end
         end
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule